// File: doc/BRIEF.md
# Single-word serial transmitter with self-clearing start flag

This block sends one 16-bit word out over a three-wire serial link (clock, data out, active-low select) each time a host asks for it. The host sees a single 32-bit control word. The low 16 bits hold the payload. Bit 17 is an arm bit. Bit 16 is a shared flag: the host writes it to 1 to launch a transfer, and the hardware clears it when the last bit has left. The host polls that flag to learn when the transfer is done.

A launch write is taken only while the link is idle and only when the arm bit is set in the same write. The engine captures the payload at launch, so later writes cannot disturb a transfer that is already running. During a transfer, host writes still update every other bit of the control word, while bit 16 keeps reading 1. The serial clock idles low. Data changes on the falling edge and is sampled on the rising edge, and the most significant bit goes first. The serial clock period is twice the parameter `HALF_DIV`, counted in system clocks.

Top module: `spi_word_tx`

## Requirements
- R1: While reset is asserted and right after it is released, the control word reads 0, select (cs_no) is high and the serial clock is low.
- R2: An idle write stores every bit of wdata_i, except bit 16, into the control word, and these bits read back unchanged on the cycle after the write.
- R3: An idle write with bit 16 = 1 and bit 17 = 1 starts a transfer. From the next cycle, bit 16 reads 1 and cs_no is low, and both stay that way for the whole transfer.
- R4: An idle write with bit 16 = 1 and bit 17 = 0 starts nothing. Bit 16 reads 0, cs_no stays high and the serial clock stays low.
- R5: The payload is bits 15:0 of the launch write, sent MSB first. mosi_o holds steady whenever sclk_o is high and at every rising edge of sclk_o.
- R6: A transfer has exactly 16 rising edges of sclk_o, spaced 2*HALF_DIV cycles apart. sclk_o is low whenever cs_no is high.
- R7: Exactly 32*HALF_DIV cycles after the launch edge, bit 16 returns to 0 and cs_no rises, with no further host action.
- R8: A write during a transfer updates all bits other than bit 16. Bit 16 stays 1 even when the write sets it again or clears it. The transfer in flight keeps its payload and its length.
- R9: After a transfer ends, the control word keeps the last written value of every bit other than bit 16, and no new transfer starts until the host issues a fresh launch write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Control word write strobe |
| wdata_i | input | REG_W | Control word write value |
| rdata_o | output | REG_W | Control word read value; bit 16 is the busy/start flag |
| sclk_o | output | 1 | Serial clock, idles low |
| mosi_o | output | 1 | Serial data out, MSB first |
| cs_no | output | 1 | Slave select, active low |

## Verification
If the busy flag and the shift engine fall out of step, it shows at the ports on the very next cycle: bit 16 and cs_no stop being opposite of each other. A wrong half-period or edge count shows up as a rising-edge spacing or a total busy length that differs from the value computed from HALF_DIV, and this is visible within one serial clock period. A shift register that is reloaded or shifted on the wrong edge gives a wrong captured word, or mosi_o moving while sclk_o is high, during the same transfer. The bench sweeps many payloads, and tests writes during a transfer, to expose each of these failures.

// File: rtl/spi_word_pkg.sv
package spi_word_pkg;
  typedef enum logic {
    XF_IDLE  = 1'b0,
    XF_SHIFT = 1'b1
  } xf_state_e;
endpackage

// File: rtl/spi_word_ctrl.sv
module spi_word_ctrl #(
  parameter int REG_W    = 32,
  parameter int DATA_W   = 16,
  parameter int BUSY_BIT = 16,
  parameter int EN_BIT   = 17
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [REG_W-1:0]  wdata_i,
  input  logic              busy_i,
  input  logic              done_i,
  output logic [REG_W-1:0]  rdata_o,
  output logic              start_o,
  output logic [DATA_W-1:0] load_o
);
  logic [REG_W-1:0] reg_q, reg_d;

  assign start_o = we_i & ~busy_i & wdata_i[BUSY_BIT] & wdata_i[EN_BIT];
  assign load_o  = wdata_i[DATA_W-1:0];

  // bit BUSY_BIT mirrors the engine; host can only raise it via a legal launch
  always_comb begin
    reg_d = reg_q;
    if (we_i) begin
      reg_d = wdata_i;
      reg_d[BUSY_BIT] = busy_i ? ~done_i : start_o;
    end else if (done_i) begin
      reg_d[BUSY_BIT] = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) reg_q <= '0;
    else         reg_q <= reg_d;
  end

  assign rdata_o = reg_q;
endmodule

// File: rtl/spi_word_div.sv
module spi_word_div #(
  parameter int HALF_DIV = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!run_i)  cnt_q <= '0;
    else if (tick_o)  cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/spi_word_shift.sv
module spi_word_shift
  import spi_word_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              tick_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              sclk_o,
  output logic              mosi_o,
  output logic              cs_no
);
  localparam int N_EDGE = 2 * DATA_W;
  localparam int EW     = $clog2(N_EDGE);
  localparam logic [EW-1:0] LAST_EDGE = EW'(N_EDGE - 1);

  xf_state_e         state_q;
  logic [DATA_W-1:0] sr_q;
  logic [EW-1:0]     edge_q;
  logic              sclk_q;

  assign busy_o = (state_q == XF_SHIFT);
  assign done_o = busy_o && tick_i && (edge_q == LAST_EDGE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= XF_IDLE;
      sr_q    <= '0;
      edge_q  <= '0;
      sclk_q  <= 1'b0;
    end else if (start_i && !busy_o) begin
      state_q <= XF_SHIFT;
      sr_q    <= data_i;
      edge_q  <= '0;
      sclk_q  <= 1'b0;
    end else if (busy_o && tick_i) begin
      sclk_q <= ~sclk_q;
      edge_q <= edge_q + 1'b1;
      // falling edge: present next bit
      if (sclk_q) sr_q <= {sr_q[DATA_W-2:0], 1'b0};
      if (done_o) begin
        state_q <= XF_IDLE;
        sclk_q  <= 1'b0;
        edge_q  <= '0;
      end
    end
  end

  assign sclk_o = sclk_q;
  assign mosi_o = sr_q[DATA_W-1];
  assign cs_no  = ~busy_o;
endmodule

// File: rtl/spi_word_tx.sv
module spi_word_tx #(
  parameter int REG_W    = 32,
  parameter int DATA_W   = 16,
  parameter int BUSY_BIT = 16,
  parameter int EN_BIT   = 17,
  parameter int HALF_DIV = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] rdata_o,
  output logic             sclk_o,
  output logic             mosi_o,
  output logic             cs_no
);
  logic              start, busy, done, tick;
  logic [DATA_W-1:0] load;

  spi_word_ctrl #(
    .REG_W(REG_W), .DATA_W(DATA_W), .BUSY_BIT(BUSY_BIT), .EN_BIT(EN_BIT)
  ) ctrl_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we_i), .wdata_i(wdata_i),
    .busy_i(busy), .done_i(done), .rdata_o(rdata_o),
    .start_o(start), .load_o(load)
  );

  spi_word_div #(.HALF_DIV(HALF_DIV)) div_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(busy), .tick_o(tick)
  );

  spi_word_shift #(.DATA_W(DATA_W)) shift_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start), .data_i(load),
    .tick_i(tick), .busy_o(busy), .done_o(done),
    .sclk_o(sclk_o), .mosi_o(mosi_o), .cs_no(cs_no)
  );
endmodule

// File: rtl/spi_word_chk.sv
module spi_word_chk #(
  parameter int REG_W    = 32,
  parameter int DATA_W   = 16,
  parameter int BUSY_BIT = 16,
  parameter int EN_BIT   = 17
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             we_i,
  input logic [REG_W-1:0] wdata_i,
  input logic [REG_W-1:0] rdata_o,
  input logic             sclk_o,
  input logic             mosi_o,
  input logic             cs_no
);
  localparam int CNT_W = $clog2(DATA_W + 1);

  logic [CNT_W-1:0] rise_cnt;
  logic             sclk_prev;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rise_cnt  <= '0;
      sclk_prev <= 1'b0;
    end else begin
      sclk_prev <= sclk_o;
      if (cs_no)                      rise_cnt <= '0;
      else if (sclk_o && !sclk_prev)  rise_cnt <= rise_cnt + 1'b1;
    end
  end

  // R6
  idle_clk_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> !sclk_o);

  // R6
  edge_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_no) |-> rise_cnt == CNT_W'(DATA_W));

  // R7
  busy_cs_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[BUSY_BIT] == !cs_no);

  // R5
  mosi_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_o |-> $stable(mosi_o));

  // R4
  start_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rdata_o[BUSY_BIT]) |-> $past(we_i && wdata_i[BUSY_BIT] && wdata_i[EN_BIT]));

  // R2
  low_track_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> rdata_o[BUSY_BIT-1:0] == $past(wdata_i[BUSY_BIT-1:0]));

  // R8
  high_track_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> rdata_o[REG_W-1:BUSY_BIT+1] == $past(wdata_i[REG_W-1:BUSY_BIT+1]));
endmodule

bind spi_word_tx spi_word_chk #(
  .REG_W(REG_W), .DATA_W(DATA_W), .BUSY_BIT(BUSY_BIT), .EN_BIT(EN_BIT)
) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we_i), .wdata_i(wdata_i),
  .rdata_o(rdata_o), .sclk_o(sclk_o), .mosi_o(mosi_o), .cs_no(cs_no)
);

// File: tb/spi_word_tx_tb_top.sv
`timescale 1ns/1ps
module spi_word_tx_tb_top;
  localparam int HALF = 2;
  localparam int BB   = 16;
  localparam int EB   = 17;
  localparam logic [31:0] BUSY = 32'h1 << BB;
  localparam logic [31:0] ARM  = 32'h1 << EB;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        we_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        sclk_o, mosi_o, cs_no;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk_i = ~clk_i;

  spi_word_tx #(.HALF_DIV(HALF)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we_i), .wdata_i(wdata_i),
    .rdata_o(rdata_o), .sclk_o(sclk_o), .mosi_o(mosi_o), .cs_no(cs_no)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic host_wr(logic [31:0] w);
    @(negedge clk_i);
    we_i = 1'b1;
    wdata_i = w;
    @(negedge clk_i);
    we_i = 1'b0;
  endtask

  task automatic run_xfer(logic [31:0] word, bit mid_en, logic [31:0] mid_w);
    logic [15:0] got = '0;
    logic        prev_s = 1'b0, prev_m = 1'b0;
    int          cyc = 0, rises = 0, last_rise = -1;
    int          space_err = 0, hold_err = 0, cs_err = 0;
    logic [31:0] arm_w, final_w;
    arm_w = (word & ~BUSY) | ARM;
    host_wr(arm_w);
    chk("R2 armed readback", rdata_o, arm_w);
    chk("R9 no start on arm", {31'b0, cs_no}, 32'h1);
    host_wr(arm_w | BUSY);
    chk("R3 busy flag", {31'b0, rdata_o[BB]}, 32'h1);
    chk("R3 select low", {31'b0, cs_no}, 32'h0);
    final_w = arm_w | BUSY;
    while (rdata_o[BB] && cyc < 1000) begin
      if (sclk_o && !prev_s) begin
        got = {got[14:0], mosi_o};
        if (last_rise >= 0 && cyc - last_rise != 2 * HALF) space_err++;
        last_rise = cyc;
        rises++;
      end
      if (sclk_o && prev_s && mosi_o !== prev_m) hold_err++;
      if (cs_no !== 1'b0) cs_err++;
      prev_s = sclk_o;
      prev_m = mosi_o;
      if (mid_en && cyc == 6) begin
        chk("R8 busy write readback", rdata_o, mid_w | BUSY);
        final_w = mid_w | BUSY;
      end
      if (mid_en && cyc == 5) begin
        we_i = 1'b1;
        wdata_i = mid_w;
      end else begin
        we_i = 1'b0;
      end
      cyc++;
      @(negedge clk_i);
    end
    we_i = 1'b0;
    chk("R7 busy length", cyc, 32 * HALF);
    chk("R5 payload msb first", {16'b0, got}, {16'b0, word[15:0]});
    chk("R6 rising edges", rises, 16);
    chk("R6 edge spacing errors", space_err, 0);
    chk("R5 mosi hold errors", hold_err, 0);
    chk("R3 select held low", cs_err, 0);
    chk("R9 readback after done", rdata_o, final_w & ~BUSY);
    chk("R7 select high after done", {30'b0, cs_no, sclk_o}, 32'h2);
    repeat (3) @(negedge clk_i);
    chk("R9 no auto restart", {31'b0, cs_no}, 32'h1);
    host_wr(final_w & ~BUSY);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finished");
    $display("  test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] w;
    repeat (3) @(negedge clk_i);
    chk("R1 reset readback", rdata_o, 32'h0);
    chk("R1 reset pins", {30'b0, cs_no, sclk_o}, 32'h2);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 after release", {rdata_o[31:2], cs_no, sclk_o}, {30'b0, 2'b10});

    // R4: launch without arm bit
    w = 32'hC001_5A5A | BUSY;
    host_wr(w);
    chk("R4 flag stays clear", rdata_o, w & ~BUSY);
    repeat (6) @(negedge clk_i);
    chk("R4 no transfer", {30'b0, cs_no, sclk_o}, 32'h2);
    host_wr(32'h0);

    // R5 one-hot sweep with varied upper bits
    for (int i = 0; i < 16; i++)
      run_xfer(((i * 32'h0135) << 18) | (32'h1 << i), 1'b0, 32'h0);

    for (int k = 0; k < 12; k++) begin
      w = (k * 32'h3C71) ^ (k << 20);
      run_xfer(w, 1'b0, 32'h0);
    end
    run_xfer(32'h0000_FFFF, 1'b0, 32'h0);
    run_xfer(32'hFFFC_0000, 1'b0, 32'h0);
    run_xfer(32'h0000_A5A5, 1'b0, 32'h0);

    // R8 writes while shifting: relaunch attempt and flag clear
    run_xfer(32'h1234_C3A5, 1'b1, 32'hABC0_0000 | ARM | BUSY | 32'h0F0F);
    run_xfer(32'h0000_5A5A, 1'b1, 32'h55D8_0000 | 32'h00F0);

    $display("  test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end
endmodule